// File: doc/BRIEF.md
# USB Host OUT Channel Sequencer

This block runs one host channel through an OUT transfer that is split into packets. Software sets a total byte count, a packet count and a maximum packet size, then pulses the enable. Bytes go into the channel's transmit data store one at a time, and the block counts them. The data store itself sits outside the block. Once a whole packet has arrived, the block pushes that packet's length into a small request queue. It also subtracts the packet length from the remaining byte count at that moment.

The entry at the head of the queue is sent to the bus side as a start pulse together with its length. The start is given only when the time left in the current frame covers the packet length plus a fixed overhead. The bus side answers with an ACK or a NAK. An ACK retires the head entry, lowers the packet count and sets a sticky ACK flag. When the last packet is acknowledged, the block also sets a transfer-finished flag. A NAK sets a sticky NAK flag and leaves the entry at the head, so the same packet is offered again. A disable pulse returns the channel to idle and discards everything in progress.

Top module: `usb_out_chan_seq`

## Requirements
- R1: A pulse on `ch_en` while the channel is idle loads `len_left` from `cfg_len` and `pcnt_left` from `cfg_pcnt`, and makes the channel active. A pulse on `ch_en` while the channel is active changes nothing.
- R2: The packet size is the smaller of `cfg_mps` and `len_left`. A queue entry is created only on the accepted byte that completes a packet. On that same edge `len_left` drops by the packet size. Bytes before the last one of a packet change neither the queue nor `len_left`.
- R3: The queue holds QDEPTH entries, and `q_level` reports how many are stored. `wr_ready` is high only when the channel is active, the queue is not full and `len_left` is nonzero. A byte offered while `wr_ready` is low is ignored.
- R4: `bus_start` pulses for one cycle, one cycle after the head entry became eligible. An entry is eligible when it is at the head, no transaction is outstanding and `frame_left` is at least the head length plus OVH. Otherwise the entry waits. `bus_len` shows the head entry's length, or zero when the queue is empty.
- R5: An ACK (`bus_ack` high while a transaction is outstanding) removes the head entry, lowers `pcnt_left` by one and sets `flags[0]`.
- R6: A NAK (`bus_nak` high with `bus_ack` low while a transaction is outstanding) sets `flags[1]`. It leaves `pcnt_left` and the head entry unchanged, so the same length is started again. If both inputs are high, the response counts as an ACK.
- R7: The ACK that takes `pcnt_left` from 1 to 0 also sets `flags[2]`, the transfer-finished flag.
- R8: The flags are sticky. Writing a 1 to a bit of `flag_clr` clears that flag. A set and a clear of the same flag on the same edge leave the flag set.
- R9: A pulse on `ch_dis` makes the channel idle on the next edge. It empties the queue, drops any partial packet and any outstanding transaction, and ignores the bus response given in that cycle. The channel can then be enabled for a new transfer.
- R10: A completed packet write and an ACK on the same edge push one entry and remove one. `q_level` stays the same, and the queue order is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable pulse |
| ch_dis | input | 1 | Channel disable pulse |
| cfg_len | input | LEN_W | Total bytes of the transfer |
| cfg_pcnt | input | PC_W | Number of packets in the transfer |
| cfg_mps | input | MPS_W | Maximum packet size in bytes (nonzero) |
| wr_valid | input | 1 | One byte is offered to the transmit store |
| wr_ready | output | 1 | Byte is accepted this cycle |
| frame_left | input | FT_W | Bus time left in the current frame |
| bus_start | output | 1 | Start an OUT transaction (one-cycle pulse) |
| bus_len | output | MPS_W | Byte length of the head entry |
| bus_ack | input | 1 | Transaction ended with ACK |
| bus_nak | input | 1 | Transaction ended with NAK |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| flags | output | 3 | Sticky flags: bit0 ACK, bit1 NAK, bit2 transfer finished |
| ch_active | output | 1 | Channel is not idle |
| len_left | output | LEN_W | Bytes not yet queued |
| pcnt_left | output | PC_W | Packets not yet acknowledged |
| q_level | output | $clog2(QDEPTH+1) | Entries in the request queue |

## Verification
Two functions can land on the same edge: the byte write that completes a packet, which pushes an entry, and an ACK, which pops the head. The directed queue-fill test triggers this by keeping `wr_valid` high while acknowledgements are arriving. A long random phase then mixes writes, responses and frame-time values freely. On every cycle the bench compares the queue level, `bus_len` and the counters against a behavioural model built on a queue, and it confirms at the end that such coincident cycles actually took place. A flag set that meets its own clear on the same edge is exercised the same way, through random values on `flag_clr`.

// File: rtl/usb_out_chan_seq.sv
module usb_out_chan_seq #(
  parameter int LEN_W  = 16,
  parameter int PC_W   = 10,
  parameter int MPS_W  = 11,
  parameter int FT_W   = 16,
  parameter int QDEPTH = 4,
  parameter int OVH    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ch_en,
  input  logic                         ch_dis,
  input  logic [LEN_W-1:0]             cfg_len,
  input  logic [PC_W-1:0]              cfg_pcnt,
  input  logic [MPS_W-1:0]             cfg_mps,
  input  logic                         wr_valid,
  output logic                         wr_ready,
  input  logic [FT_W-1:0]              frame_left,
  output logic                         bus_start,
  output logic [MPS_W-1:0]             bus_len,
  input  logic                         bus_ack,
  input  logic                         bus_nak,
  input  logic [2:0]                   flag_clr,
  output logic [2:0]                   flags,
  output logic                         ch_active,
  output logic [LEN_W-1:0]             len_left,
  output logic [PC_W-1:0]              pcnt_left,
  output logic [$clog2(QDEPTH+1)-1:0]  q_level
);

  localparam int QAW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW    = $clog2(QDEPTH + 1);
  localparam int CMP_W = ((FT_W > MPS_W) ? FT_W : MPS_W) + 2;

  logic             active, in_flight, start_q;
  logic [LEN_W-1:0] len_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [MPS_W-1:0] fill_q;
  logic [2:0]       flags_q;
  logic [MPS_W-1:0] q_mem [QDEPTH];
  logic [QAW-1:0]   rd_ptr, wr_ptr;
  logic [CW-1:0]    q_cnt;

  logic [MPS_W-1:0] psize, head;
  logic             q_full, q_empty, wr_fire, pkt_done;
  logic             eligible, issue, ack_hit, nak_hit;

  assign q_full   = (q_cnt == CW'(QDEPTH));
  assign q_empty  = (q_cnt == '0);
  assign head     = q_mem[rd_ptr];
  assign psize    = (len_q < LEN_W'(cfg_mps)) ? MPS_W'(len_q) : cfg_mps;

  assign wr_ready = active && !q_full && (len_q != '0);
  assign wr_fire  = wr_valid && wr_ready && !ch_dis;
  assign pkt_done = wr_fire && ((fill_q + MPS_W'(1)) == psize);

  assign eligible = active && !in_flight && !q_empty &&
                    (CMP_W'(frame_left) >= CMP_W'(head) + CMP_W'(OVH));
  assign issue    = eligible && !ch_dis;
  assign ack_hit  = in_flight && bus_ack && !ch_dis;
  assign nak_hit  = in_flight && !bus_ack && bus_nak && !ch_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      in_flight <= 1'b0;
      start_q   <= 1'b0;
      len_q     <= '0;
      pcnt_q    <= '0;
      fill_q    <= '0;
    end else if (ch_dis) begin
      active    <= 1'b0;
      in_flight <= 1'b0;
      start_q   <= 1'b0;
      fill_q    <= '0;
    end else begin
      start_q <= issue;
      if (!active && ch_en) begin
        active <= 1'b1;
        len_q  <= cfg_len;
        pcnt_q <= cfg_pcnt;
        fill_q <= '0;
      end
      if (issue)
        in_flight <= 1'b1;
      else if (ack_hit || nak_hit)
        in_flight <= 1'b0;
      if (ack_hit && pcnt_q != '0)
        pcnt_q <= pcnt_q - PC_W'(1);
      if (wr_fire)
        fill_q <= pkt_done ? '0 : fill_q + MPS_W'(1);
      if (pkt_done)
        len_q <= len_q - LEN_W'(psize);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      q_cnt  <= '0;
    end else if (ch_dis) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      q_cnt  <= '0;
    end else begin
      if (pkt_done)
        wr_ptr <= (wr_ptr == QAW'(QDEPTH - 1)) ? '0 : wr_ptr + QAW'(1);
      if (ack_hit)
        rd_ptr <= (rd_ptr == QAW'(QDEPTH - 1)) ? '0 : rd_ptr + QAW'(1);
      q_cnt <= q_cnt + CW'(pkt_done) - CW'(ack_hit);
    end
  end

  always_ff @(posedge clk)
    if (pkt_done) q_mem[wr_ptr] <= psize;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) |
                           {ack_hit && (pcnt_q == PC_W'(1)), nak_hit, ack_hit};
  end

  assign bus_start = start_q;
  assign bus_len   = q_empty ? '0 : head;
  assign flags     = flags_q;
  assign ch_active = active;
  assign len_left  = len_q;
  assign pcnt_left = pcnt_q;
  assign q_level   = q_cnt;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= CW'(QDEPTH));

  p_en_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_active && ch_en && !ch_dis) |=> ch_active);

  p_start_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> (q_level != '0));

  p_start_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> (CMP_W'($past(frame_left)) >= CMP_W'(bus_len) + CMP_W'(OVH)));

  p_ack_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && bus_ack && !ch_dis && pcnt_left != '0) |=>
      (pcnt_left == $past(pcnt_left) - PC_W'(1)));

  p_nak_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight && !bus_ack && bus_nak && !ch_dis) |=>
      (pcnt_left == $past(pcnt_left) && q_level >= $past(q_level)));

  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> (pcnt_left == '0));

  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ch_dis |=> (!ch_active && q_level == '0 && !bus_start));

endmodule

// File: tb/usb_out_chan_seq_tb.sv
module usb_out_chan_seq_tb;
  localparam int LEN_W = 16, PC_W = 10, MPS_W = 11, FT_W = 16, QD = 4, OVH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_en = 0, ch_dis = 0, wr_valid = 0, bus_ack = 0, bus_nak = 0;
  logic [LEN_W-1:0] cfg_len = 0;
  logic [PC_W-1:0]  cfg_pcnt = 0;
  logic [MPS_W-1:0] cfg_mps = 1;
  logic [FT_W-1:0]  frame_left = 0;
  logic [2:0]       flag_clr = 0;
  logic             wr_ready, bus_start, ch_active;
  logic [MPS_W-1:0] bus_len;
  logic [2:0]       flags;
  logic [LEN_W-1:0] len_left;
  logic [PC_W-1:0]  pcnt_left;
  logic [2:0]       q_level;

  always #5 clk = ~clk;

  usb_out_chan_seq #(.LEN_W(LEN_W), .PC_W(PC_W), .MPS_W(MPS_W), .FT_W(FT_W),
                     .QDEPTH(QD), .OVH(OVH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_dis(ch_dis), .cfg_len(cfg_len),
    .cfg_pcnt(cfg_pcnt), .cfg_mps(cfg_mps), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .frame_left(frame_left), .bus_start(bus_start), .bus_len(bus_len),
    .bus_ack(bus_ack), .bus_nak(bus_nak), .flag_clr(flag_clr), .flags(flags),
    .ch_active(ch_active), .len_left(len_left), .pcnt_left(pcnt_left), .q_level(q_level));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference model
  int q[$];
  int m_len = 0, m_pc = 0, m_fill = 0, m_flags = 0, m_both = 0, m_starts = 0;
  bit m_act = 0, m_inf = 0, m_start = 0;
  int ps, setv;
  bit rdy, iss, popd, pushd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 0; m_pc = 0; m_fill = 0; m_flags = 0;
      m_act = 0; m_inf = 0; m_start = 0; q.delete();
    end else begin
      ps    = (m_len < int'(cfg_mps)) ? m_len : int'(cfg_mps);
      rdy   = m_act && q.size() < QD && m_len != 0;
      setv  = 0; popd = 0; pushd = 0;
      if (ch_dis) begin
        m_act = 0; m_inf = 0; m_fill = 0; m_start = 0; q.delete();
      end else begin
        iss = m_act && !m_inf && q.size() != 0 && int'(frame_left) >= q[0] + OVH;
        m_start = iss;
        if (iss) m_starts++;
        if (!m_act && ch_en) begin
          m_act = 1; m_len = int'(cfg_len); m_pc = int'(cfg_pcnt); m_fill = 0;
        end
        if (m_inf && bus_ack) begin
          setv |= 1; if (m_pc == 1) setv |= 4;
          if (m_pc != 0) m_pc--;
          popd = 1; m_inf = 0;
        end else if (m_inf && bus_nak) begin
          setv |= 2; m_inf = 0;
        end
        if (wr_valid && rdy) begin
          if (m_fill + 1 == ps) begin pushd = 1; m_len -= ps; m_fill = 0; end
          else m_fill++;
        end
        if (popd) void'(q.pop_front());
        if (pushd) q.push_back(ps);
        if (popd && pushd) m_both++;
        if (iss) m_inf = 1;
      end
      m_flags = (m_flags & ~int'(flag_clr)) | setv;
    end
  end

  // bus-side responder
  int resp_mode = 0, rwait = 2;
  bit force_nak = 0;
  always @(negedge clk) begin
    if (resp_mode != 0 && m_inf) begin
      if (rwait == 0) begin
        if (resp_mode == 2) begin
          bus_ack = ($urandom % 3) != 0; bus_nak = !bus_ack || ($urandom % 4 == 0);
          rwait = 1 + $urandom % 3;
        end else begin
          bus_ack = !force_nak; bus_nak = force_nak; force_nak = 0; rwait = 2;
        end
      end else begin
        bus_ack = 0; bus_nak = 0; rwait--;
      end
    end else begin
      bus_ack = 0; bus_nak = 0; rwait = 2;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R3", "wr_ready", int'(wr_ready), int'(m_act && q.size() < QD && m_len != 0));
    chk("R4", "bus_start", int'(bus_start), int'(m_start));
    chk("R4", "bus_len", int'(bus_len), (q.size() != 0) ? q[0] : 0);
    chk("R8", "flags", int'(flags), m_flags);
    chk("R9", "ch_active", int'(ch_active), int'(m_act));
    chk("R2", "len_left", int'(len_left), m_len);
    chk("R5", "pcnt_left", int'(pcnt_left), m_pc);
    chk("R10", "q_level", int'(q_level), q.size());
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic start_xfer(int len, int pc, int mps);
    cfg_len = LEN_W'(len); cfg_pcnt = PC_W'(pc); cfg_mps = MPS_W'(mps);
    ch_en = 1; step(); ch_en = 0;
  endtask

  task automatic run_until_done(int limit);
    for (int i = 0; i < limit && m_pc != 0; i++) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R1", "reset idle", int'(ch_active), 0);
    chk("R8", "reset flags", int'(flags), 0);

    // R1 R2 R5 R6 R7: 10 bytes in packets of 4,4,2; first response a NAK
    frame_left = 1000; resp_mode = 1; force_nak = 1;
    start_xfer(10, 3, 4);
    chk("R1", "load len", int'(len_left), 10);
    wr_valid = 1;
    step(); step(); step();
    chk("R2", "partial write keeps len", int'(len_left), 10);
    cfg_len = 99; cfg_pcnt = 99; ch_en = 1; step(); ch_en = 0;
    chk("R1", "enable while active ignored", int'(pcnt_left) == 99 ? 0 : 1, 1);
    run_until_done(200);
    wr_valid = 0;
    step();
    chk("R7", "transfer finished flag", int'(flags[2]), 1);
    chk("R6", "nak flag seen", int'(flags[1]), 1);
    chk("R5", "ack flag seen", int'(flags[0]), 1);
    chk("R6", "retry start count", m_starts, 4);

    // R8 clear, R9 disable
    flag_clr = 3'b111; step(); flag_clr = 0;
    chk("R8", "w1c cleared", int'(flags), 0);
    ch_dis = 1; step(); ch_dis = 0;
    chk("R9", "idle after disable", int'(ch_active), 0);

    // R4 frame-time gating
    frame_left = 10;
    start_xfer(8, 1, 8);
    wr_valid = 1;
    repeat (8) step();
    wr_valid = 0;
    repeat (10) step();
    chk("R4", "entry waits for frame time", int'(q_level), 1);
    chk("R4", "no ack without start", int'(pcnt_left), 1);
    frame_left = 24;
    run_until_done(50);
    chk("R4", "sent once time sufficient", int'(pcnt_left), 0);
    ch_dis = 1; step(); ch_dis = 0;

    // R3 queue full, R10 coincident push/pop
    frame_left = 1000; resp_mode = 0;
    start_xfer(40, 10, 4);
    wr_valid = 1;
    repeat (30) step();
    chk("R3", "queue full", int'(q_level), QD);
    chk("R3", "ready low when full", int'(wr_ready), 0);
    chk("R3", "writes blocked", int'(len_left), 24);
    resp_mode = 1;
    run_until_done(400);
    wr_valid = 0;
    step();
    ch_dis = 1; step(); ch_dis = 0;

    // random phase
    resp_mode = 2;
    for (int i = 0; i < 5000; i++) begin
      wr_valid   = ($urandom % 3) != 0;
      frame_left = FT_W'($urandom % 48);
      flag_clr   = ($urandom % 6 == 0) ? 3'($urandom) : 3'b000;
      ch_dis     = ($urandom % 300 == 0);
      ch_en      = ($urandom % 20 == 0);
      if (ch_en) begin
        cfg_mps  = MPS_W'(1 + $urandom % 8);
        cfg_len  = LEN_W'(1 + $urandom % 40);
        cfg_pcnt = PC_W'((int'(cfg_len) + int'(cfg_mps) - 1) / int'(cfg_mps));
      end
      step();
      if (!m_act || m_pc == 0) begin
        if (m_act && $urandom % 4 == 0) begin ch_dis = 1; step(); end
      end
      ch_dis = 0;
    end
    chk("R10", "coincident push and pop observed", int'(m_both > 0), 1);
    finish_run();
  end
endmodule